// File: doc/BRIEF.md
# Reload Timer with Pulse-Width Output

This block is a 16-bit upward-counting timer with a software preload. Software writes a start value N. While counting is allowed, the count rises from N one step at a time until it reaches all ones. On the next allowed step the count takes N again, and a timeout event occurs. Every timeout sets a sticky interrupt flag. Software clears that flag with a write-one-to-clear strobe.

Counting is gated by two synchronous enable strobes, one from a fast clock source and one from a slow one. The count advances only in cycles where both strobes are high.

The timeouts also step a 4-bit phase counter, so one output period spans sixteen timeouts. The pulse output is high for the first D of those sixteen timeouts. D is a 4-bit duty field held in a control word. With this output the timer can drive a motor or a similar load at sixteen duty levels.

Top module: `preload_timer_pwm`

## Requirements
- R1: A write with `wr_sel`=0 loads `wr_data` into both the preload register and the live count on the next clock edge. After that, each allowed step adds one to the count.
- R2: An allowed step taken while the count is 16'hFFFF is a timeout. On that edge the count takes the preload value, and `irq` is high from the following cycle.
- R3: A step is allowed only in a cycle where both `fast_en` and `slow_en` are 1. If either one is 0, the count holds its value.
- R4: Each timeout adds one to a 4-bit phase counter. The phase counter wraps from 15 to 0, so one output period is 16 timeouts long.
- R5: A write with `wr_sel`=1 stores `wr_data[9:6]` as the duty value D. All other bits of that write are ignored. `pwm_out` is high exactly when the phase is below D. With D=0 the output stays low for the whole period, and with D=3 it is high for 3 of 16 timeouts.
- R6: `irq` is sticky. A cycle with `irq_clr`=1 clears it. If a timeout and `irq_clr` fall in the same cycle, the timeout wins and `irq` stays high.
- R7: A preload write takes priority over a step in the same cycle. No timeout occurs in that cycle, even if the count was 16'hFFFF.
- R8: A synchronous active-high `rst` clears the count, the preload, the duty value, the phase counter and `irq` to zero. While reset is held, `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects preload, 1 selects control word |
| wr_data | input | 16 | Write data |
| fast_en | input | 1 | Fast source enable strobe |
| slow_en | input | 1 | Slow source enable strobe |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq | output | 1 | Sticky timeout interrupt request |
| pwm_out | output | 1 | Pulse-width output |

## Verification
Directed runs load preloads just below all ones, so that the exact cycle of the wrap shows whether the count starts at N and steps by one. Those runs also hold each gate input low in turn, which tells a gate built as AND apart from one built as OR. A preload of all ones makes every allowed step a timeout. This walks the phase through full periods at duty values 0, 3 and 15, which exposes off-by-one errors in the duty compare and in the phase wrap. Random enables, clears and writes biased toward high preload values then hit the collisions: a write against a wrap, and a clear against a set.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
    typedef enum logic {
        SEL_PRELOAD = 1'b0,
        SEL_CTRL    = 1'b1
    } wsel_e;
endpackage

// File: rtl/rtp_counter.sv
module rtp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         timeout_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] pre;
    } cnt_state_t;

    localparam logic [W-1:0] TOP = {W{1'b1}};

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        if (load) begin
            st_d.pre = load_val;
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == TOP) begin
                st_d.cnt  = st_q.pre;
                timeout_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(st_q.cnt));
    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (st_q.cnt == $past(load_val)) && (st_q.pre == $past(load_val)));
    p_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && st_q.cnt == TOP) |=> st_q.cnt == $past(st_q.pre));
    p_wr_first_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> !timeout_o);
endmodule

// File: rtl/rtp_pwm.sv
module rtp_pwm #(
    parameter int W        = 16,
    parameter int PW       = 4,
    parameter int DUTY_LSB = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_wr,
    input  logic [W-1:0] ctrl_data,
    input  logic         step,
    output logic         pwm_o
);
    localparam int DUTY_MSB = DUTY_LSB + PW - 1;

    typedef struct packed {
        logic [PW-1:0] duty;
        logic [PW-1:0] phase;
    } pwm_state_t;

    pwm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.duty  = ctrl_data[DUTY_MSB:DUTY_LSB];
        if (step)    st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pwm_o = (st_q.phase < st_q.duty);

    p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> st_q.phase == PW'($past(st_q.phase) + 1'b1));
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q.phase));
    p_duty_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(st_q.duty));
endmodule

// File: rtl/rtp_irq.sv
module rtp_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag_q);
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/preload_timer_pwm.sv
module preload_timer_pwm #(
    parameter int W        = 16,
    parameter int PW       = 4,
    parameter int DUTY_LSB = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         fast_en,
    input  logic         slow_en,
    input  logic         irq_clr,
    output logic         irq,
    output logic         pwm_out
);
    import rtp_pkg::*;

    logic tick, pre_wr, ctrl_wr, timeout;

    assign tick    = fast_en & slow_en;
    assign pre_wr  = wr_en && (wsel_e'(wr_sel) == SEL_PRELOAD);
    assign ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

    rtp_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(pre_wr),
        .load_val(wr_data), .timeout_o(timeout)
    );

    rtp_pwm #(.W(W), .PW(PW), .DUTY_LSB(DUTY_LSB)) u_pwm (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(wr_data),
        .step(timeout), .pwm_o(pwm_out)
    );

    rtp_irq u_irq (
        .clk(clk), .rst(rst), .set(timeout), .clr(irq_clr), .flag_o(irq)
    );

    p_irq_follow_r2: assert property (@(posedge clk) disable iff (rst)
        timeout |=> irq);
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !(fast_en && slow_en) |-> !timeout);
endmodule

// File: tb/preload_timer_pwm_bench.sv
`timescale 1ns/1ps
module preload_timer_pwm_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fast_en = 1'b0, slow_en = 1'b0, irq_clr = 1'b0;
    logic        irq, pwm_out;

    int total = 0, bad = 0, cyc = 0;
    logic [15:0] m_cnt = '0, m_pre = '0;
    logic [3:0]  m_duty = '0, m_ph = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    preload_timer_pwm u_preload_timer_pwm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fast_en(fast_en), .slow_en(slow_en), .irq_clr(irq_clr),
        .irq(irq), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic exp_pwm(input logic [3:0] ph, input logic [3:0] d);
        return ph < d;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = 1'b1; wr_en = 1'b0; fast_en = 1'b0; slow_en = 1'b0; irq_clr = 1'b0;
            @(posedge clk);
            m_cnt = '0; m_pre = '0; m_duty = '0; m_ph = '0; m_irq = 1'b0;
            #1;
            chk("R8", "irq", irq, 1'b0);
            chk("R8", "pwm", pwm_out, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply(input logic we, input logic ws, input logic [15:0] wd,
                         input logic f, input logic s, input logic c, input string tag);
        logic tk, pw, tmo;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd; fast_en = f; slow_en = s; irq_clr = c;
        @(posedge clk);
        tk  = f & s;
        pw  = we & ~ws;
        tmo = tk & ~pw & (m_cnt == 16'hFFFF);
        if (pw) begin
            m_pre = wd; m_cnt = wd;
        end else if (tk) begin
            m_cnt = (m_cnt == 16'hFFFF) ? m_pre : m_cnt + 16'd1;
        end
        if (we & ws) m_duty = wd[9:6];
        if (tmo) m_ph = m_ph + 4'd1;
        if (tmo) m_irq = 1'b1;
        else if (c) m_irq = 1'b0;
        #1;
        chk(tag, "irq", irq, m_irq);
        chk(tag, "pwm", pwm_out, exp_pwm(m_ph, m_duty));
    endtask

    task automatic idle(input string tag);
        apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset(3);

        // R1 / R2: load FFFD, two steps reach FFFF, third step wraps
        apply(1'b1, 1'b0, 16'hFFFD, 1'b0, 1'b0, 1'b0, "R1");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R1");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R1");
        chk("R1", "irq before wrap", irq, 1'b0);
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R2");
        chk("R2", "irq after wrap", irq, 1'b1);
        // reload to FFFD: needs three more steps
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1, "R2");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R2");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R2");
        chk("R2", "irq after reload period", irq, 1'b1);

        // R6: clear with no timeout
        apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, "R6");
        chk("R6", "irq cleared", irq, 1'b0);
        idle("R6");
        chk("R6", "irq stays clear", irq, 1'b0);

        // R3: gating with one source low
        apply(1'b1, 1'b0, 16'hFFFE, 1'b0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R3");
        chk("R3", "irq while gated", irq, 1'b0);
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R3");
        chk("R3", "irq at FFFF", irq, 1'b0);
        // R6: set and clear together, set wins
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1, "R6");
        chk("R6", "set beats clear", irq, 1'b1);

        // R5 / R4: duty 3 with noise bits, every step a timeout
        apply(1'b1, 1'b1, 16'hF03F | (16'd3 << 6), 1'b0, 1'b0, 1'b1, "R5");
        apply(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 32; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R4");
        // R5: duty 0 stays low
        apply(1'b1, 1'b1, 16'hFC3F, 1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 16; i++) begin
            apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R5");
            chk("R5", "duty0 low", pwm_out, 1'b0);
        end
        // R5: duty 15
        apply(1'b1, 1'b1, 16'd15 << 6, 1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 16; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R5");

        // R7: write beats wrap at FFFF
        apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, "R7");
        apply(1'b1, 1'b0, 16'h0010, 1'b1, 1'b1, 1'b0, "R7");
        chk("R7", "no timeout on write", irq, 1'b0);
        apply(1'b1, 1'b0, 16'hFFFE, 1'b1, 1'b1, 1'b0, "R7");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R7");
        apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, "R7");
        chk("R7", "wrap after live load", irq, 1'b1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic we, ws, f, s, c;
            logic [15:0] wd;
            we = ($urandom % 16) == 0;
            ws = $urandom % 2;
            wd = ws ? 16'($urandom) : {12'hFFF, 4'($urandom)};
            f  = ($urandom % 4) != 0;
            s  = ($urandom % 4) != 0;
            c  = ($urandom % 8) == 0;
            apply(we, ws, wd, f, s, c, (i % 2) ? "R2" : "R5");
        end

        // R8: reset in the middle of a run
        do_reset(2);
        idle("R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule